// File: doc/BRIEF.md
# Doorbell Command Mailbox Controller

This block is the register front end of a host-to-device command mailbox. The host sees a small register window: a capability word, a control word whose bit 0 is the doorbell, a 64-bit command word, a 64-bit status word, a background-progress word and a 2048-byte payload window. The host fills in the payload and the command word, then rings the doorbell with a 32-bit write to the control word.

On the doorbell the block first walks the payload buffer one 64-bit word per cycle. Each word is copied into a snapshot buffer and then zeroed. It then offers the latched command to a device-side execution port. The executor reads its input bytes from the snapshot and writes its output words into the live payload. It signals completion with a one-cycle done pulse that carries a return code, an output length and a background-started bit. The block then rebuilds the status and command words and drops the doorbell. Dropping the doorbell is the host's completion signal.

Command semantics, interrupt delivery and the source of the background-progress values all stay outside the block. The background values arrive as plain inputs. The request side of the execution port is valid/ready: `exe_req_valid` stays high with stable fields until the cycle in which `exe_req_ready` is high, and the executor may stall it for any number of cycles. Nothing can stall the done pulse. It is accepted only after the request has been taken.

Top module: `mbx_doorbell_ctrl`

Host map: capability at 0x00, control at 0x04, command at 0x08, status at 0x10, background progress at 0x18, payload at 0x20 to 0x81F. Size codes on `host_size`: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. Data is right-justified and accesses are naturally aligned. Command word fields: opcode [7:0], command set [15:8], length [36:16]. Status word fields: background-started flag [0], return code [47:32]. Register reads return the whole register whatever the size; payload reads return the addressed bytes right-justified. Read data appears one cycle after `host_rd`, together with `host_rvalid`.

## Requirements
- R1: After reset the capability word reads 0x4CB. That is a payload size code of 11 in bits [4:0], background-interrupt capability in bit 6 and message number 9 in bits [10:7]. Control, command and status all read 0.
- R2: A write at any width to 0x20 through 0x81F stores exactly the addressed bytes (byte k of the data goes to address+k). A payload read returns those bytes right-justified, and a payload write never starts a command.
- R3: The status word (0x10) ignores host writes; only completion and the clear-on-read of R10 change it.
- R4: An 8-byte write is taken only at 0x08 (and at 0x18, where it has no visible effect). A 4-byte write is taken only at 0x04 (and at 0x00, where the capability is constant). Every other register write, by offset or width, is ignored.
- R5: A 4-byte write of bit 0 = 1 to 0x04 with length at most 2048 sets the doorbell and zeroes the payload one word per cycle. `exe_req_valid` then rises exactly 256 cycles after the write edge, carrying the command set, opcode and length from the command word.
- R6: While `exe_req_valid` is high and `exe_req_ready` is low, the request and its fields hold steady.
- R7: `exe_in_data` returns the payload contents as they stood before the clear, and the live payload reads zero until the executor writes it.
- R8: A done pulse after the request is taken writes status = {return code at [47:32], background flag at [0]}. It writes the command word back with the same set and opcode and the output length, and clears the doorbell in the same edge.
- R9: An 8-byte read of 0x18 returns the background opcode in [15:0], percent complete in [22:16] and the background return code in [47:32].
- R10: An 8-byte read of 0x10 while the background percent is nonzero returns, and keeps, the status with bit 0 cleared. With the percent at zero the flag is left alone.
- R11: While the doorbell is set, host writes to the command word, payload and control are ignored, and the control word reads 1.
- R12: A doorbell with a length above 2048 issues no request and leaves the payload untouched. One cycle later the status holds return code 0x0001, the command length reads 0, and the doorbell is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| host_wr | input | 1 | host write strobe |
| host_rd | input | 1 | host read strobe |
| host_addr | input | 12 | byte address in the window |
| host_size | input | 2 | access size code |
| host_wdata | input | 64 | right-justified write data |
| host_rdata | output | 64 | read data, one cycle after the strobe |
| host_rvalid | output | 1 | read data valid |
| bg_opcode | input | 16 | background command opcode |
| bg_pct | input | 7 | background percent complete |
| bg_rc | input | 16 | background return code |
| exe_req_valid | output | 1 | command request valid |
| exe_req_ready | input | 1 | executor accepts request |
| exe_req_set | output | 8 | command set |
| exe_req_op | output | 8 | opcode |
| exe_req_len | output | 21 | input length in bytes |
| exe_in_addr | input | 8 | snapshot word index |
| exe_in_data | output | 64 | snapshot word |
| exe_out_we | input | 1 | executor payload word write |
| exe_out_addr | input | 8 | payload word index |
| exe_out_data | input | 64 | payload word data |
| exe_done | input | 1 | completion pulse |
| exe_done_rc | input | 16 | return code |
| exe_done_len | input | 21 | output length |
| exe_done_bg | input | 1 | background operation started |

## Verification
On every cycle the assertions check four things: the request stays steady under back-pressure, the doorbell is set whenever the sequencer is busy, the clear sweep advances one word per cycle, and host writes never move the status word. They also check that the doorbell falls only on a completion and that an oversized length never reaches the request port. Only the scenarios can show that field packing, the snapshot contents, the clear-on-read persistence and the exact 256-cycle issue latency are right. The same holds for the many write offsets and widths that must be dropped.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int OFS_CAP  = 'h00;
  localparam int OFS_CTRL = 'h04;
  localparam int OFS_CMD  = 'h08;
  localparam int OFS_STS  = 'h10;
  localparam int OFS_BGS  = 'h18;
  localparam int OFS_PL   = 'h20;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;
  localparam logic [1:0] SZ_D = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CLEAR, ST_ISSUE, ST_RUN, ST_REJECT
  } seq_state_e;
endpackage

// File: rtl/mbx_payload.sv
module mbx_payload #(
  parameter int WORDS = 256,
  parameter int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [7:0]       host_be,
  input  logic [63:0]      host_wd,
  output logic [63:0]      host_rword,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             exe_we,
  input  logic [IDX_W-1:0] exe_idx,
  input  logic [63:0]      exe_wd,
  input  logic [IDX_W-1:0] snap_idx,
  output logic [63:0]      snap_rword
);
  logic [63:0] live_q [WORDS];
  logic [63:0] snap_q [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) begin
        live_q[i] <= '0;
        snap_q[i] <= '0;
      end
    end else if (clr_en) begin
      snap_q[clr_idx] <= live_q[clr_idx];
      live_q[clr_idx] <= '0;
    end else if (exe_we) begin
      live_q[exe_idx] <= exe_wd;
    end else if (host_we) begin
      for (int b = 0; b < 8; b++)
        if (host_be[b]) live_q[host_idx][8*b +: 8] <= host_wd[8*b +: 8];
    end
  end

  assign host_rword = live_q[host_idx];
  assign snap_rword = snap_q[snap_idx];
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
#(
  parameter int WORDS = 256,
  parameter int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  logic             start_err,
  input  logic             req_ready,
  input  logic             done,
  output logic             clr_en,
  output logic [IDX_W-1:0] clr_idx,
  output logic             req_valid,
  output logic             running,
  output logic             fin_ok,
  output logic             fin_err,
  output logic             busy
);
  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_err) state_q <= ST_REJECT;
          else if (start_ok) begin
            state_q <= ST_CLEAR;
            idx_q   <= '0;
          end
        end
        ST_CLEAR: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_W'(WORDS - 1)) state_q <= ST_ISSUE;
        end
        ST_ISSUE:  if (req_ready) state_q <= ST_RUN;
        ST_RUN:    if (done) state_q <= ST_IDLE;
        ST_REJECT: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign clr_en    = (state_q == ST_CLEAR);
  assign clr_idx   = idx_q;
  assign req_valid = (state_q == ST_ISSUE);
  assign running   = (state_q == ST_RUN);
  assign fin_ok    = running && done;
  assign fin_err   = (state_q == ST_REJECT);
  assign busy      = (state_q != ST_IDLE);

  // R5: the clear sweep steps one word per cycle until the last word
  a_r5_sweep_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLEAR && idx_q != IDX_W'(WORDS - 1))
      |=> (state_q == ST_CLEAR && idx_q == $past(idx_q) + 1'b1));

  // R5: after the last word is cleared the request is offered
  a_r5_sweep_end: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLEAR && idx_q == IDX_W'(WORDS - 1)) |=> req_valid);
endmodule

// File: rtl/mbx_doorbell_ctrl.sv
module mbx_doorbell_ctrl
  import mbx_pkg::*;
#(
  parameter int          PAYLOAD_BYTES = 2048,
  parameter int          ADDR_W        = 12,
  parameter int          LEN_W         = 21,
  parameter int          RC_W          = 16,
  parameter logic [15:0] ERR_RC        = 16'h0001,
  parameter int          SIZE_CODE     = 11,
  parameter int          MSG_NUM       = 9,
  localparam int         WORDS         = PAYLOAD_BYTES / 8,
  localparam int         IDX_W         = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [1:0]        host_size,
  input  logic [63:0]       host_wdata,
  output logic [63:0]       host_rdata,
  output logic              host_rvalid,
  input  logic [15:0]       bg_opcode,
  input  logic [6:0]        bg_pct,
  input  logic [15:0]       bg_rc,
  output logic              exe_req_valid,
  input  logic              exe_req_ready,
  output logic [7:0]        exe_req_set,
  output logic [7:0]        exe_req_op,
  output logic [LEN_W-1:0]  exe_req_len,
  input  logic [IDX_W-1:0]  exe_in_addr,
  output logic [63:0]       exe_in_data,
  input  logic              exe_out_we,
  input  logic [IDX_W-1:0]  exe_out_addr,
  input  logic [63:0]       exe_out_data,
  input  logic              exe_done,
  input  logic [RC_W-1:0]   exe_done_rc,
  input  logic [LEN_W-1:0]  exe_done_len,
  input  logic              exe_done_bg
);
  localparam int          PL_END  = OFS_PL + PAYLOAD_BYTES;
  localparam logic [63:0] CAP_VAL = 64'(SIZE_CODE) | (64'd1 << 6) | (64'(MSG_NUM) << 7);

  function automatic logic [63:0] build_cmd(input logic [7:0] s, input logic [7:0] o,
                                            input logic [LEN_W-1:0] l);
    build_cmd = '0;
    build_cmd[7:0] = o;
    build_cmd[15:8] = s;
    build_cmd[16 +: LEN_W] = l;
  endfunction

  function automatic logic [63:0] build_sts(input logic [RC_W-1:0] rc, input logic bg);
    build_sts = '0;
    build_sts[0] = bg;
    build_sts[32 +: RC_W] = rc;
  endfunction

  logic             db_q;
  logic [63:0]      cmd_q, sts_q, rdata_q;
  logic             rvalid_q;
  logic             busy, running, fin_ok, fin_err, clr_en;
  logic [IDX_W-1:0] clr_idx;
  logic [63:0]      pl_rword;

  // address decode
  logic [ADDR_W:0]   addr_x;
  logic [ADDR_W-1:0] pl_off;
  logic [IDX_W-1:0]  pl_idx;
  logic [2:0]        lane;
  logic              is_pl, at_cap, at_ctrl, at_cmd, at_sts, at_bgs;

  assign addr_x  = {1'b0, host_addr};
  assign is_pl   = (addr_x >= (ADDR_W+1)'(OFS_PL)) && (addr_x < (ADDR_W+1)'(PL_END));
  assign pl_off  = host_addr - ADDR_W'(OFS_PL);
  assign pl_idx  = pl_off[IDX_W+2:3];
  assign lane    = host_addr[2:0];
  assign at_cap  = (host_addr == ADDR_W'(OFS_CAP));
  assign at_ctrl = (host_addr == ADDR_W'(OFS_CTRL));
  assign at_cmd  = (host_addr == ADDR_W'(OFS_CMD));
  assign at_sts  = (host_addr == ADDR_W'(OFS_STS));
  assign at_bgs  = (host_addr == ADDR_W'(OFS_BGS));

  // byte-lane shaping for the payload window
  logic [7:0]  be_base;
  logic [63:0] size_mask;
  always_comb begin
    case (host_size)
      SZ_B:    begin be_base = 8'h01; size_mask = 64'h0000_0000_0000_00FF; end
      SZ_H:    begin be_base = 8'h03; size_mask = 64'h0000_0000_0000_FFFF; end
      SZ_W:    begin be_base = 8'h0F; size_mask = 64'h0000_0000_FFFF_FFFF; end
      default: begin be_base = 8'hFF; size_mask = '1; end
    endcase
  end

  // write acceptance
  logic wr_ok, wr_cmd, wr_ctrl, ring, too_long, start_ok, start_err, pl_we, rd_clr;
  logic [LEN_W-1:0] cmd_len;

  assign cmd_len   = cmd_q[16 +: LEN_W];
  assign wr_ok     = host_wr && !busy;
  assign wr_cmd    = wr_ok && host_size == SZ_D && at_cmd;
  assign wr_ctrl   = wr_ok && host_size == SZ_W && at_ctrl;
  assign ring      = wr_ctrl && host_wdata[0];
  assign too_long  = cmd_len > LEN_W'(PAYLOAD_BYTES);
  assign start_ok  = ring && !too_long;
  assign start_err = ring && too_long;
  assign pl_we     = wr_ok && is_pl;
  assign rd_clr    = host_rd && host_size == SZ_D && at_sts && (bg_pct != '0);

  mbx_seq #(.WORDS(WORDS), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ok  (start_ok),
    .start_err (start_err),
    .req_ready (exe_req_ready),
    .done      (exe_done),
    .clr_en    (clr_en),
    .clr_idx   (clr_idx),
    .req_valid (exe_req_valid),
    .running   (running),
    .fin_ok    (fin_ok),
    .fin_err   (fin_err),
    .busy      (busy)
  );

  mbx_payload #(.WORDS(WORDS), .IDX_W(IDX_W)) u_payload (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (pl_we),
    .host_idx   (pl_idx),
    .host_be    (8'(be_base << lane)),
    .host_wd    (host_wdata << {lane, 3'b000}),
    .host_rword (pl_rword),
    .clr_en     (clr_en),
    .clr_idx    (clr_idx),
    .exe_we     (exe_out_we && running),
    .exe_idx    (exe_out_addr),
    .exe_wd     (exe_out_data),
    .snap_idx   (exe_in_addr),
    .snap_rword (exe_in_data)
  );

  // register state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q  <= 1'b0;
      cmd_q <= '0;
      sts_q <= '0;
    end else begin
      if (fin_ok || fin_err) db_q <= 1'b0;
      else if (wr_ctrl)      db_q <= host_wdata[0];

      if (fin_ok)       cmd_q <= build_cmd(cmd_q[15:8], cmd_q[7:0], exe_done_len);
      else if (fin_err) cmd_q <= build_cmd(cmd_q[15:8], cmd_q[7:0], '0);
      else if (wr_cmd)  cmd_q <= host_wdata;

      if (fin_ok)       sts_q <= build_sts(exe_done_rc, exe_done_bg);
      else if (fin_err) sts_q <= build_sts(RC_W'(ERR_RC), 1'b0);
      else if (rd_clr)  sts_q[0] <= 1'b0;
    end
  end

  // read path
  logic [63:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (at_cap)       rd_val = CAP_VAL;
    else if (at_ctrl) rd_val = 64'(db_q);
    else if (at_cmd)  rd_val = cmd_q;
    else if (at_sts)  rd_val = rd_clr ? {sts_q[63:1], 1'b0} : sts_q;
    else if (at_bgs)  rd_val = 64'(bg_opcode) | (64'(bg_pct) << 16) | (64'(bg_rc) << 32);
    else if (is_pl)   rd_val = (pl_rword >> {lane, 3'b000}) & size_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= host_rd;
      if (host_rd) rdata_q <= rd_val;
    end
  end

  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;
  assign exe_req_set = cmd_q[15:8];
  assign exe_req_op  = cmd_q[7:0];
  assign exe_req_len = cmd_len;

  // R6: a stalled request keeps its valid and its fields
  a_r6_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_req_valid && !exe_req_ready)
      |=> (exe_req_valid && $stable({exe_req_set, exe_req_op, exe_req_len})));

  // R11: the sequencer is never busy with the doorbell down
  a_r11_db_busy: assert property (@(posedge clk) disable iff (!rst_n) busy |-> db_q);

  // R3: host writes do not move the status word
  a_r3_sts_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_rd && !fin_ok && !fin_err) |=> $stable(sts_q));

  // R8: the doorbell drops only on a completion
  a_r8_db_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(db_q) |-> $past(fin_ok || fin_err));

  // R12: an oversized length never reaches the request port
  a_r12_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    exe_req_valid |-> (exe_req_len <= LEN_W'(PAYLOAD_BYTES)));
endmodule

// File: tb/mbx_doorbell_ctrl_bench.sv
module mbx_doorbell_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PB = 2048;
  localparam int NW = PB / 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr, host_rd;
  logic [11:0] host_addr;
  logic [1:0]  host_size;
  logic [63:0] host_wdata, host_rdata;
  logic        host_rvalid;
  logic [15:0] bg_opcode, bg_rc;
  logic [6:0]  bg_pct;
  logic        exe_req_valid, exe_req_ready;
  logic [7:0]  exe_req_set, exe_req_op;
  logic [20:0] exe_req_len;
  logic [7:0]  exe_in_addr, exe_out_addr;
  logic [63:0] exe_in_data, exe_out_data;
  logic        exe_out_we, exe_done, exe_done_bg;
  logic [15:0] exe_done_rc;
  logic [20:0] exe_done_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_doorbell_ctrl u_mbx_doorbell_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .bg_opcode(bg_opcode), .bg_pct(bg_pct), .bg_rc(bg_rc),
    .exe_req_valid(exe_req_valid), .exe_req_ready(exe_req_ready),
    .exe_req_set(exe_req_set), .exe_req_op(exe_req_op), .exe_req_len(exe_req_len),
    .exe_in_addr(exe_in_addr), .exe_in_data(exe_in_data),
    .exe_out_we(exe_out_we), .exe_out_addr(exe_out_addr), .exe_out_data(exe_out_data),
    .exe_done(exe_done), .exe_done_rc(exe_done_rc), .exe_done_len(exe_done_len),
    .exe_done_bg(exe_done_bg)
  );

  // reference model state
  logic [7:0]  mdl_pl   [PB];
  logic [7:0]  mdl_snap [PB];
  logic [63:0] mdl_cmd, mdl_sts;
  logic        mdl_db, mdl_busy, mdl_req, mdl_start;
  int          mdl_left, mdl_rej;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // model timing of clear sweep and reject path, advanced at each edge
  always @(posedge clk) begin
    if (mdl_req && exe_req_ready) mdl_req = 1'b0;
    if (mdl_start) begin
      mdl_left = NW;
      mdl_start = 1'b0;
    end else if (mdl_left > 0) begin
      mdl_left--;
      if (mdl_left == 0) mdl_req = 1'b1;
    end
    if (mdl_rej == 2) begin
      mdl_sts = 64'h0001 << 32;
      mdl_cmd = {27'b0, 21'd0, mdl_cmd[15:0]};
      mdl_db = 1'b0;
      mdl_busy = 1'b0;
      mdl_rej = 0;
    end else if (mdl_rej == 1) mdl_rej = 2;
  end

  // per-cycle comparison of the request port (R5, R6, R12)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R5/R12 request valid", 64'(exe_req_valid), 64'(mdl_req));
      if (mdl_req) begin
        check("R5/R6 request set", 64'(exe_req_set), 64'(mdl_cmd[15:8]));
        check("R5/R6 request op", 64'(exe_req_op), 64'(mdl_cmd[7:0]));
        check("R5/R6 request len", 64'(exe_req_len), 64'(mdl_cmd[36:16]));
      end
    end
  end

  task automatic mdl_write(input int a, input int s, input logic [63:0] d);
    if (mdl_busy) return;
    if (a >= 32 && a < 32 + PB) begin
      for (int b = 0; b < (1 << s); b++) mdl_pl[a - 32 + b] = d[8*b +: 8];
    end else if (s == 3 && a == 8) mdl_cmd = d;
    else if (s == 2 && a == 4) begin
      mdl_db = d[0];
      if (d[0]) begin
        mdl_busy = 1'b1;
        if (int'(mdl_cmd[36:16]) > PB) mdl_rej = 1;
        else begin
          for (int i = 0; i < PB; i++) begin
            mdl_snap[i] = mdl_pl[i];
            mdl_pl[i] = 8'h00;
          end
          mdl_start = 1'b1;
        end
      end
    end
  endtask

  task automatic mdl_read(input int a, input int s, output logic [63:0] v);
    v = '0;
    if (a == 0) v = 64'd11 | (64'd1 << 6) | (64'd9 << 7);
    else if (a == 4) v = 64'(mdl_db);
    else if (a == 8) v = mdl_cmd;
    else if (a == 16) begin
      if (s == 3 && bg_pct != 0) mdl_sts[0] = 1'b0;
      v = mdl_sts;
    end else if (a == 24) v = 64'(bg_opcode) | (64'(bg_pct) << 16) | (64'(bg_rc) << 32);
    else if (a >= 32 && a < 32 + PB)
      for (int b = 0; b < (1 << s); b++) v[8*b +: 8] = mdl_pl[a - 32 + b];
  endtask

  task automatic hwr(input int a, input int s, input logic [63:0] d);
    host_addr = 12'(a); host_size = 2'(s); host_wdata = d; host_wr = 1'b1;
    mdl_write(a, s, d);
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hrd(input int a, input int s, input string tag);
    logic [63:0] e;
    host_addr = 12'(a); host_size = 2'(s); host_rd = 1'b1;
    mdl_read(a, s, e);
    @(negedge clk);
    host_rd = 1'b0;
    check(tag, host_rdata, e);
  endtask

  task automatic exe_write(input int w, input logic [63:0] d);
    exe_out_we = 1'b1; exe_out_addr = 8'(w); exe_out_data = d;
    @(negedge clk);
    exe_out_we = 1'b0;
    for (int b = 0; b < 8; b++) mdl_pl[w*8 + b] = d[8*b +: 8];
  endtask

  task automatic exe_finish(input logic [15:0] rc, input logic [20:0] len, input logic bg);
    exe_done = 1'b1; exe_done_rc = rc; exe_done_len = len; exe_done_bg = bg;
    @(negedge clk);
    exe_done = 1'b0;
    mdl_sts = (64'(rc) << 32) | 64'(bg);
    mdl_cmd = {27'b0, len, mdl_cmd[15:0]};
    mdl_db = 1'b0;
    mdl_busy = 1'b0;
  endtask

  task automatic summary();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int n;
    logic [63:0] w;
    rst_n = 1'b0; host_wr = 0; host_rd = 0; host_addr = '0; host_size = '0; host_wdata = '0;
    bg_opcode = '0; bg_pct = '0; bg_rc = '0; exe_req_ready = 0; exe_in_addr = '0;
    exe_out_we = 0; exe_out_addr = '0; exe_out_data = '0; exe_done = 0;
    exe_done_rc = '0; exe_done_len = '0; exe_done_bg = 0;
    for (int i = 0; i < PB; i++) begin mdl_pl[i] = 0; mdl_snap[i] = 0; end
    mdl_cmd = '0; mdl_sts = '0; mdl_db = 0; mdl_busy = 0; mdl_req = 0; mdl_start = 0;
    mdl_left = 0; mdl_rej = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    hrd(0, 2, "R1 capability");
    hrd(4, 2, "R1 control after reset");
    hrd(8, 3, "R1 command after reset");
    hrd(16, 3, "R1 status after reset");

    // R2 payload writes at every width
    hwr('h20, 3, 64'h1122_3344_5566_7788);
    hwr('h29, 0, 64'h0000_0000_0000_00AB);
    hwr('h2A, 1, 64'h0000_0000_0000_CDEF);
    hwr('h2C, 2, 64'h0000_0000_DEAD_BEEF);
    hwr('h81F, 0, 64'h5A);
    hrd('h20, 3, "R2 payload dword");
    hrd('h28, 3, "R2 payload mixed widths");
    hrd('h2A, 1, "R2 payload half read");
    hrd('h2F, 0, "R2 payload byte read");
    hrd('h81F, 0, "R2 payload top byte");

    // R4 width and offset filtering
    hwr(8, 3, 64'h0000_0000_0010_4102);
    hwr(8, 2, 64'hFFFF_FFFF);
    hrd(8, 3, "R4 narrow write to command dropped");
    hwr(4, 0, 64'h1);
    hwr(4, 3, 64'h1);
    hrd(4, 2, "R4 wrong-width doorbell dropped");
    hwr(0, 2, 64'hFFFF_FFFF);
    hrd(0, 2, "R4 capability constant");
    hwr(24, 3, 64'hFFFF_FFFF_FFFF_FFFF);

    // R3 status read-only
    hwr(16, 3, 64'hFFFF_FFFF_FFFF_FFFF);
    hrd(16, 3, "R3 status write dropped");

    // R9 background packing
    bg_opcode = 16'h4402; bg_pct = 7'd0; bg_rc = 16'h00A1;
    hrd(24, 3, "R9 background progress");

    // R5 ring doorbell, R11 writes while busy
    hwr(4, 2, 64'h1);
    hwr(8, 3, 64'h0000_0000_0FFF_FFFF);
    hwr('h20, 0, 64'h99);
    hrd(4, 2, "R11 doorbell held while busy");
    n = 3;
    while (!exe_req_valid && n < 1000) begin @(negedge clk); n++; end
    check("R5 issue latency", 64'(n), 64'(NW));
    repeat (3) @(negedge clk);
    exe_req_ready = 1'b1;
    @(negedge clk);
    exe_req_ready = 1'b0;

    // R7 snapshot and cleared live payload
    for (int k = 0; k < 2; k++) begin
      exe_in_addr = 8'(k);
      #1;
      for (int b = 0; b < 8; b++) w[8*b +: 8] = mdl_snap[k*8 + b];
      check("R7 snapshot word", exe_in_data, w);
    end
    hrd('h20, 3, "R7 live payload cleared");
    hrd('h81F, 0, "R7 top payload cleared");
    hwr(8, 3, 64'h0);
    hrd(8, 3, "R11 command write during run dropped");

    // R8 completion
    exe_write(0, 64'hA5A5_0102_0304_0506);
    exe_finish(16'h0007, 21'd8, 1'b1);
    hrd(4, 2, "R8 doorbell cleared");
    hrd(8, 3, "R8 command rebuilt");
    hrd(16, 3, "R8 status rebuilt");
    hrd('h20, 3, "R8 output payload");

    // R10 clear-on-read
    hrd(16, 3, "R10 flag kept at zero percent");
    bg_pct = 7'd40;
    hrd(16, 3, "R10 flag cleared on read");
    bg_pct = 7'd0;
    hrd(16, 3, "R10 cleared flag persists");

    // R12 oversized length
    hwr(8, 3, (64'd3000 << 16) | 64'h0203);
    hwr(4, 2, 64'h1);
    @(negedge clk);
    hrd(4, 2, "R12 doorbell cleared");
    hrd(16, 3, "R12 internal error code");
    hrd(8, 3, "R12 length zeroed");
    hrd('h20, 3, "R12 payload untouched");

    repeat (2) @(negedge clk);
    summary();
  end
endmodule